// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns outbound local-bus addresses into link-side addresses by means of a small set of programmable windows. Each window has a 64-bit base, a 32-bit inclusive limit, a 64-bit target, a 3-bit transaction-kind code and an enable bit. Software does not address the windows directly. It first writes a selector word that names one window, and then reaches that window's fields through a fixed group of register offsets.

For each request, the block searches the enabled windows for one that contains the address. It returns the target plus the offset of the address from the window's base, together with the window's transaction kind. For the two configuration kinds it also returns the bus/device/function field held in the target word. The result appears one clock after the request. An address that no window claims passes through unchanged and raises a miss flag.

Top module: `atu_outbound`

## Requirements
- R1: After synchronous reset every window is disabled and all window fields read 0. The selector reads 0, `o_valid` is low, and the first request after reset misses.
- R2: The selector sits at offset 0x900. Bit 31 is the direction (0 = outbound) and bits 3:0 hold the window index; both read back as written. Offsets 0x904 (kind, bits 2:0), 0x908 (bit 31 enable, bit 30 bar-mode), 0x90C (base low), 0x910 (base high), 0x914 (limit), 0x918 (target low) and 0x91C (target high) read and write the selected window.
- R3: While the selector names the inbound direction, or an index of `NUM_REGIONS` or more, writes to the window offsets change no window and reads from them return 0.
- R4: A window matches when it is enabled, `req_addr[63:32]` equals its base high word, and base low ≤ `req_addr[31:0]` ≤ limit. Both ends of the window are included.
- R5: Every request with `req_valid` high gives `o_valid` high exactly one clock later, with `o_addr` = target + (`req_addr` − base) of the matching window.
- R6: `o_type` carries the matching window's kind code: 0 memory, 2 I/O, 4 type-0 configuration, 5 type-1 configuration.
- R7: For kinds 4 and 5, `o_bdf` equals target-low bits 31:16: bus in 15:8, device in 7:3, function in 2:0. For every other result `o_bdf` is 0.
- R8: When several enabled windows match, the one with the lowest index wins and its index is output on `o_region`.
- R9: When no window matches, `o_miss` is high, `o_addr` equals `req_addr`, and `o_type`, `o_bdf` and `o_region` are 0.
- R10: A field write takes effect for any request presented on a later clock. Re-programming one window between configuration and memory kinds changes the results accordingly.
- R11: The bar-mode bit is stored and read back but has no effect on matching. Clearing the enable bit removes the window from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from `cfg_addr`) |
| req_valid | input | 1 | Outbound request present |
| req_addr | input | 64 | Local address of request |
| o_valid | output | 1 | Translation result valid |
| o_addr | output | 64 | Translated (or passed-through) address |
| o_type | output | 3 | Transaction kind code |
| o_bdf | output | 16 | Bus/device/function for configuration kinds |
| o_miss | output | 1 | No window matched |
| o_region | output | 4 | Index of the winning window |

## Verification
A corrupted window field shows up on the very next translated result. The address offset, the kind or the routing field comes out wrong, or the result flips into a miss. Every result is sampled one clock after its request, so a fault is seen within two cycles of the stimulus. A fault in the selector or write gating that lands on the wrong window is exposed by reading the fields back and by requests aimed at both ends of each window. The same checks catch writes that leak into the wrong window while inbound or out-of-range indices are selected.

// File: rtl/atu_pkg.sv
package atu_pkg;
    localparam int AW       = 64;
    localparam int DW       = 32;
    localparam int OFS_W    = 12;
    localparam int VP_IDX_W = 4;

    localparam logic [OFS_W-1:0] OFS_SEL    = 12'h900;
    localparam logic [OFS_W-1:0] OFS_KIND   = 12'h904;
    localparam logic [OFS_W-1:0] OFS_CTL    = 12'h908;
    localparam logic [OFS_W-1:0] OFS_BASE_L = 12'h90C;
    localparam logic [OFS_W-1:0] OFS_BASE_H = 12'h910;
    localparam logic [OFS_W-1:0] OFS_LIMIT  = 12'h914;
    localparam logic [OFS_W-1:0] OFS_TGT_L  = 12'h918;
    localparam logic [OFS_W-1:0] OFS_TGT_H  = 12'h91C;

    typedef enum logic [2:0] {
        XK_MEM  = 3'd0,
        XK_IO   = 3'd2,
        XK_CFG0 = 3'd4,
        XK_CFG1 = 3'd5
    } xkind_e;

    typedef struct packed {
        logic [DW-1:0] base_l;
        logic [DW-1:0] base_h;
        logic [DW-1:0] limit;
        logic [DW-1:0] tgt_l;
        logic [DW-1:0] tgt_h;
        logic [2:0]    kind;
        logic          en;
        logic          bar;
    } win_t;

    typedef struct packed {
        logic [AW-1:0]       addr;
        logic [2:0]          kind;
        logic [15:0]         bdf;
        logic                miss;
        logic [VP_IDX_W-1:0] idx;
    } xres_t;

    function automatic logic is_cfg_kind(input logic [2:0] k);
        return (k == XK_CFG0) || (k == XK_CFG1);
    endfunction
endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [OFS_W-1:0] cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output win_t             wins [NUM_REGIONS]
);
    localparam logic [VP_IDX_W-1:0] NREG_V = VP_IDX_W'(NUM_REGIONS);

    logic                sel_dir;
    logic [VP_IDX_W-1:0] sel_idx;
    logic                sel_ok;
    win_t                cur;

    assign sel_ok = !sel_dir && (sel_idx < NREG_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_dir <= 1'b0;
            sel_idx <= '0;
        end else if (cfg_wr && cfg_addr == OFS_SEL) begin
            sel_dir <= cfg_wdata[31];
            sel_idx <= cfg_wdata[VP_IDX_W-1:0];
        end
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                wins[r] <= '0;
            end else if (cfg_wr && sel_ok && sel_idx == VP_IDX_W'(r)) begin
                case (cfg_addr)
                    OFS_KIND:   wins[r].kind   <= cfg_wdata[2:0];
                    OFS_CTL: begin
                                wins[r].en     <= cfg_wdata[31];
                                wins[r].bar    <= cfg_wdata[30];
                    end
                    OFS_BASE_L: wins[r].base_l <= cfg_wdata;
                    OFS_BASE_H: wins[r].base_h <= cfg_wdata;
                    OFS_LIMIT:  wins[r].limit  <= cfg_wdata;
                    OFS_TGT_L:  wins[r].tgt_l  <= cfg_wdata;
                    OFS_TGT_H:  wins[r].tgt_h  <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cur = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (sel_ok && sel_idx == VP_IDX_W'(r)) cur = wins[r];
        end
    end

    always_comb begin
        case (cfg_addr)
            OFS_SEL:    cfg_rdata = {sel_dir, {(DW-1-VP_IDX_W){1'b0}}, sel_idx};
            OFS_KIND:   cfg_rdata = {29'b0, cur.kind};
            OFS_CTL:    cfg_rdata = {cur.en, cur.bar, 30'b0};
            OFS_BASE_L: cfg_rdata = cur.base_l;
            OFS_BASE_H: cfg_rdata = cur.base_h;
            OFS_LIMIT:  cfg_rdata = cur.limit;
            OFS_TGT_L:  cfg_rdata = cur.tgt_l;
            OFS_TGT_H:  cfg_rdata = cur.tgt_h;
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/atu_window_match.sv
module atu_window_match
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 3
) (
    input  win_t          wins [NUM_REGIONS],
    input  logic [AW-1:0] addr,
    output xres_t         res
);
    logic [NUM_REGIONS-1:0] hit;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
        assign hit[r] = wins[r].en
                     && addr[AW-1:DW] == wins[r].base_h
                     && addr[DW-1:0] >= wins[r].base_l
                     && addr[DW-1:0] <= wins[r].limit;
    end

    always_comb begin
        res      = '0;
        res.addr = addr;
        res.miss = 1'b1;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (hit[r]) begin
                res.addr = {wins[r].tgt_h, wins[r].tgt_l}
                         + (addr - {wins[r].base_h, wins[r].base_l});
                res.kind = wins[r].kind;
                res.bdf  = is_cfg_kind(wins[r].kind) ? wins[r].tgt_l[31:16] : 16'h0;
                res.miss = 1'b0;
                res.idx  = VP_IDX_W'(r);
            end
        end
    end
endmodule

// File: rtl/atu_outbound.sv
module atu_outbound
    import atu_pkg::*;
#(
    parameter int NUM_REGIONS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [OFS_W-1:0]    cfg_addr,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    input  logic                req_valid,
    input  logic [AW-1:0]       req_addr,
    output logic                o_valid,
    output logic [AW-1:0]       o_addr,
    output logic [2:0]          o_type,
    output logic [15:0]         o_bdf,
    output logic                o_miss,
    output logic [VP_IDX_W-1:0] o_region
);
    win_t  wins [NUM_REGIONS];
    xres_t res_d;
    xres_t res_q;

    atu_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .wins      (wins)
    );

    atu_window_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .wins (wins),
        .addr (req_addr),
        .res  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            res_q   <= '0;
        end else begin
            o_valid <= req_valid;
            if (req_valid) res_q <= res_d;
        end
    end

    assign o_addr   = res_q.addr;
    assign o_type   = res_q.kind;
    assign o_bdf    = res_q.bdf;
    assign o_miss   = res_q.miss;
    assign o_region = res_q.idx;
endmodule

// File: rtl/atu_outbound_chk.sv
module atu_outbound_chk
    import atu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [AW-1:0]       req_addr,
    input logic                o_valid,
    input logic [AW-1:0]       o_addr,
    input logic [2:0]          o_type,
    input logic [15:0]         o_bdf,
    input logic                o_miss,
    input logic [VP_IDX_W-1:0] o_region
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !o_valid);

    // R5
    result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> o_valid);

    // R5
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !o_valid);

    // R9
    miss_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid ##1 (o_valid && o_miss)) |->
            (o_addr == $past(req_addr) && o_type == 3'd0 && o_bdf == 16'h0 && o_region == '0));

    // R7
    bdf_only_for_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !is_cfg_kind(o_type)) |-> o_bdf == 16'h0);
endmodule

bind atu_outbound atu_outbound_chk u_chk (.*);

// File: tb/sim_atu_outbound.sv
module sim_atu_outbound;
    import atu_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_wr = 1'b0;
    logic [OFS_W-1:0]    cfg_addr = '0;
    logic [DW-1:0]       cfg_wdata = '0;
    logic [DW-1:0]       cfg_rdata;
    logic                req_valid = 1'b0;
    logic [AW-1:0]       req_addr = '0;
    logic                o_valid;
    logic [AW-1:0]       o_addr;
    logic [2:0]          o_type;
    logic [15:0]         o_bdf;
    logic                o_miss;
    logic [VP_IDX_W-1:0] o_region;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    atu_outbound #(.NUM_REGIONS(3)) u0 (.*);

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] ea;
        logic [2:0]  et;
        logic [15:0] eb;
        logic        em;
        logic [3:0]  er;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{64'h0000_0000_1000_0000, 64'h0000_0000_0100_0000, 3'd4, 16'h0100, 1'b0, 4'd0},
        '{64'h0000_0000_1000_0FFF, 64'h0000_0000_0100_0FFF, 3'd4, 16'h0100, 1'b0, 4'd0},
        '{64'h0000_0000_1000_1000, 64'h0000_0000_1000_1000, 3'd0, 16'h0000, 1'b1, 4'd0},
        '{64'h0000_0000_2000_0010, 64'h0000_0001_4000_0010, 3'd0, 16'h0000, 1'b0, 4'd1},
        '{64'h0000_0000_2FFF_FFFF, 64'h0000_0001_4FFF_FFFF, 3'd0, 16'h0000, 1'b0, 4'd1},
        '{64'h0000_0000_3000_0004, 64'h0000_0000_0000_1004, 3'd2, 16'h0000, 1'b0, 4'd2},
        '{64'h0000_0000_3001_0000, 64'h0000_0000_3001_0000, 3'd0, 16'h0000, 1'b1, 4'd0},
        '{64'h0000_0001_2000_0000, 64'h0000_0001_2000_0000, 3'd0, 16'h0000, 1'b1, 4'd0},
        '{64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0FFF_FFFF, 3'd0, 16'h0000, 1'b1, 4'd0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic req(input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic prog(input int idx, input logic [2:0] k, input logic [63:0] base,
                        input logic [31:0] lim, input logic [63:0] tgt);
        wr(12'h900, 32'(idx));
        wr(12'h904, {29'b0, k});
        wr(12'h90C, base[31:0]);
        wr(12'h910, base[63:32]);
        wr(12'h914, lim);
        wr(12'h918, tgt[31:0]);
        wr(12'h91C, tgt[63:32]);
        wr(12'h908, 32'h8000_0000);
    endtask

    task automatic chk_res(input string tag, input vec_t v);
        chk({tag, " valid"},  {63'b0, o_valid}, 64'd1);
        chk({tag, " addr"},   o_addr, v.ea);
        chk({tag, " type"},   {61'b0, o_type}, {61'b0, v.et});
        chk({tag, " bdf"},    {48'b0, o_bdf}, {48'b0, v.eb});
        chk({tag, " miss"},   {63'b0, o_miss}, {63'b0, v.em});
        chk({tag, " region"}, {60'b0, o_region}, {60'b0, v.er});
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 o_valid", {63'b0, o_valid}, 64'd0);
        rd(12'h900, d); chk("R1 selector", {32'b0, d}, 64'd0);
        rd(12'h908, d); chk("R1 ctl", {32'b0, d}, 64'd0);
        rd(12'h914, d); chk("R1 limit", {32'b0, d}, 64'd0);
        req(64'h0);
        chk_res("R1 first req", '{64'h0, 64'h0, 3'd0, 16'h0, 1'b1, 4'd0});

        prog(0, 3'd4, 64'h0000_0000_1000_0000, 32'h1000_0FFF, 64'h0000_0000_0100_0000);
        prog(1, 3'd0, 64'h0000_0000_2000_0000, 32'h2FFF_FFFF, 64'h0000_0001_4000_0000);
        prog(2, 3'd2, 64'h0000_0000_3000_0000, 32'h3000_FFFF, 64'h0000_0000_0000_1000);

        // R2: readback of selected window
        rd(12'h900, d); chk("R2 selector", {32'b0, d}, 64'd2);
        rd(12'h904, d); chk("R2 kind", {32'b0, d}, 64'd2);
        rd(12'h910, d); chk("R2 base high", {32'b0, d}, 64'd0);
        rd(12'h918, d); chk("R2 target low", {32'b0, d}, 64'h1000);
        wr(12'h900, 32'd1);
        rd(12'h91C, d); chk("R2 target high r1", {32'b0, d}, 64'd1);

        // R4 R5 R6 R7 R9: vector table
        foreach (VECS[i]) begin
            req(VECS[i].a);
            chk_res($sformatf("R4 R5 R6 R7 R9 vec%0d", i), VECS[i]);
        end

        // R3: inbound direction selected
        wr(12'h900, 32'h8000_0000);
        rd(12'h900, d); chk("R2 R3 selector dir", {32'b0, d}, 64'h8000_0000);
        wr(12'h908, 32'h0);
        rd(12'h90C, d); chk("R3 inbound read", {32'b0, d}, 64'd0);
        wr(12'h900, 32'd0);
        rd(12'h908, d); chk("R3 ctl kept", {32'b0, d}, 64'h8000_0000);
        req(64'h1000_0000); chk_res("R3 still hits", VECS[0]);

        // R3: out-of-range index
        wr(12'h900, 32'd3);
        wr(12'h914, 32'h0);
        rd(12'h914, d); chk("R3 index3 read", {32'b0, d}, 64'd0);
        req(64'h1000_0FFF); chk_res("R3 limit kept", VECS[1]);

        // R11: bar-mode bit stored, no effect
        wr(12'h900, 32'd0);
        wr(12'h908, 32'hC000_0000);
        rd(12'h908, d); chk("R11 bar readback", {32'b0, d}, 64'hC000_0000);
        req(64'h1000_0000); chk_res("R11 bar no effect", VECS[0]);

        // R8: overlap, lowest index wins
        prog(2, 3'd5, 64'h0000_0000_2000_0000, 32'h2000_FFFF, 64'h0000_0000_0219_0000);
        req(64'h2000_0100);
        chk_res("R8 overlap", '{64'h2000_0100, 64'h0000_0001_4000_0100, 3'd0, 16'h0, 1'b0, 4'd1});

        // R11: disable window 1, window 2 takes over
        wr(12'h900, 32'd1);
        wr(12'h908, 32'h0);
        req(64'h2000_0100);
        chk_res("R11 R7 disabled", '{64'h2000_0100, 64'h0000_0000_0219_0100, 3'd5, 16'h0219, 1'b0, 4'd2});

        // R10: window 0 turned from configuration into memory
        wr(12'h900, 32'd0);
        wr(12'h904, 32'd0);
        req(64'h1000_0008);
        chk_res("R10 reprogram", '{64'h1000_0008, 64'h0000_0000_0100_0008, 3'd0, 16'h0, 1'b0, 4'd0});

        // R5: no result without request
        @(negedge clk);
        chk("R5 idle", {63'b0, o_valid}, 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule